// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address. It starts from a context table in memory and then descends through up to three levels of page tables. It reaches memory through one read/write port that carries a single transaction at a time. A walk may end at a page entry on level 1, 2 or 3, which maps a 16 MB, 256 KB or 4 KB region. A bad entry ends the walk with a fault code that packs the level and the kind of failure. When a walk succeeds, the walker sets the referenced bit of the final entry and, for a write, its modified bit. It stores the entry back only when one of those bits was clear. Permission checking and any translation cache sit outside this block.

The finite-state machine has four states:

| State | Role |
|---|---|
| `S_IDLE` | Waits for a start request. |
| `S_FETCH` | Reads one entry. |
| `S_STORE` | Writes an updated entry back. |
| `S_REPORT` | Presents the result for one cycle. |

Transitions:

| From | To | Condition |
|---|---|---|
| `S_IDLE` | `S_REPORT` | Start while translation is off. |
| `S_IDLE` | `S_FETCH` | Start while translation is on. |
| `S_FETCH` | `S_FETCH` | The entry is a table descriptor; go to the next level. |
| `S_FETCH` | `S_STORE` | The entry is a page entry whose status bits must change. |
| `S_FETCH` | `S_REPORT` | The entry is a page entry with nothing to store, or the entry is a fault. |
| `S_STORE` | `S_REPORT` | The write is accepted. |
| `S_REPORT` | `S_IDLE` | Always. |

Top module: `tblwalk_top`

## Requirements
- R1: When `mmu_enable` is low at start, `walk_done` rises in the cycle after the start. `walk_pa` then equals the virtual address zero-extended to 36 bits, `walk_fault` is 0, and no memory transaction is issued.
- R2: With translation on, the first read goes to `{ctx_table_ptr, 4'b0} + ctx_index*4`.
- R3: Bits [1:0] of each entry give its kind: 0 invalid, 1 table descriptor, 2 page entry, 3 reserved. A descriptor leads to the table at `{entry[31:2], 2'b00} << 4`. The index into that table is VA[31:24] on level 1, VA[23:18] on level 2 and VA[17:12] on level 3, each index times 4.
- R4: `walk_fault` = (level << 8) | (kind << 2). Kind 1 means an invalid entry. Kind 4 means a translation error, such as a reserved entry. Level 0 is the context entry.
- R5: A page entry found in the context entry is a translation error, and so is a descriptor found on level 3.
- R6: A page entry on level 1, 2 or 3 gives `walk_pa = {entry[31:8], 12'b0}` plus VA[23:0], VA[17:0] or VA[11:0] respectively.
- R7: On success the walker sets entry bit 5 (referenced), and also bit 6 (modified) when `walk_write` is high. The updated entry is written to the address it was read from only if a bit changed. `walk_entry` shows the updated value.
- R8: `mem_valid`, `mem_addr`, `mem_write` and `mem_wdata` hold steady until `mem_ready`. Only one transaction is in flight at a time.
- R9: A start is taken only in the idle state; a start during a walk is ignored. Each walk gives exactly one `walk_done` pulse, one cycle long.
- R10: On a fault, `walk_pa` is 0, `walk_entry` is the entry that failed, and no write-back happens.
- R11: After reset the walker is idle, with `walk_done` and `mem_valid` low and the results at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_start | input | 1 | Start strobe, taken in idle only |
| walk_va | input | 32 | Virtual address to translate |
| walk_write | input | 1 | The access is a write |
| mmu_enable | input | 1 | Translation on |
| ctx_table_ptr | input | 32 | Context table pointer (byte address >> 4) |
| ctx_index | input | CTX_W | Context number |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | Request is a write |
| mem_addr | output | 36 | Physical byte address of the entry |
| mem_wdata | output | 32 | Entry written back |
| mem_ready | input | 1 | Memory accepts or completes the request |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| walk_done | output | 1 | One-cycle completion pulse |
| walk_pa | output | 36 | Translated physical address |
| walk_entry | output | 32 | Final entry (updated) or faulting entry |
| walk_fault | output | 12 | Fault code, 0 when the walk succeeds |

## Verification
The assertions check, on every cycle, the rules that hold whatever is in memory: the request stays stable while stalled, `walk_done` lasts one cycle, fault codes keep their bit layout, a faulting walk gives a zero address, every stored entry has its referenced bit set, and translation-off completes in one cycle. Address arithmetic, page sizes, the conditions for a write-back and the level where each fault arises all depend on table contents. Only the bench's prepared page tables can show those, along with its stalled handshakes and the start requests it sends while a walk is busy.

// File: rtl/tblwalk_pkg.sv
package tblwalk_pkg;
    localparam int VA_W   = 32;
    localparam int ENT_W  = 32;
    localparam int PA_W   = 36;
    localparam int LVL_W  = 2;
    localparam int FLT_W  = 12;
    localparam int KIND_W = 3;

    // Status bit positions inside an entry
    localparam int REF_BIT = 5;
    localparam int MOD_BIT = 6;

    typedef enum logic [1:0] {
        EK_INVALID = 2'd0,
        EK_TABLE   = 2'd1,
        EK_PAGE    = 2'd2,
        EK_RESV    = 2'd3
    } entry_kind_e;

    localparam logic [KIND_W-1:0] FK_INVALID = 3'd1;
    localparam logic [KIND_W-1:0] FK_XLATE   = 3'd4;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FETCH,
        S_STORE,
        S_REPORT
    } walk_state_e;
endpackage

// File: rtl/tblwalk_index.sv
module tblwalk_index
    import tblwalk_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic [LVL_W-1:0]  next_lvl,
    input  logic [31:12]      va_hi,
    input  logic [ENT_W-1:2]  desc_hi,
    input  logic [31:0]       ctx_ptr,
    input  logic [CTX_W-1:0]  ctx_num,
    output logic [PA_W-1:0]   ctx_addr,
    output logic [PA_W-1:0]   next_addr
);
    localparam int IDX_W = 8;

    logic [IDX_W-1:0] idx;

    always_comb begin
        unique case (next_lvl)
            2'd1:    idx = va_hi[31:24];
            2'd2:    idx = {2'b00, va_hi[23:18]};
            2'd3:    idx = {2'b00, va_hi[17:12]};
            default: idx = '0;
        endcase
    end

    assign ctx_addr  = {ctx_ptr, 4'b0000} + PA_W'({ctx_num, 2'b00});
    assign next_addr = {desc_hi, 2'b00, 4'b0000} + PA_W'({idx, 2'b00});
endmodule

// File: rtl/tblwalk_classify.sv
module tblwalk_classify
    import tblwalk_pkg::*;
(
    input  logic [LVL_W-1:0] lvl,
    input  logic [ENT_W-1:0] entry,
    input  logic             is_write,
    output logic             go_deeper,
    output logic             is_page,
    output logic [FLT_W-1:0] fault_code,
    output logic [ENT_W-1:0] upd_entry,
    output logic             need_store
);
    entry_kind_e       kind;
    logic [KIND_W-1:0] fkind;

    assign kind = entry_kind_e'(entry[1:0]);

    always_comb begin
        go_deeper = 1'b0;
        is_page   = 1'b0;
        fkind     = '0;
        unique case (kind)
            EK_INVALID: fkind = FK_INVALID;
            EK_RESV:    fkind = FK_XLATE;
            EK_TABLE: begin
                if (lvl == 2'd3) fkind = FK_XLATE;
                else             go_deeper = 1'b1;
            end
            EK_PAGE: begin
                if (lvl == 2'd0) fkind = FK_XLATE;
                else             is_page = 1'b1;
            end
            default: fkind = FK_XLATE;
        endcase
    end

    assign fault_code = {2'b00, lvl, 3'b000, fkind, 2'b00};

    always_comb begin
        upd_entry = entry;
        upd_entry[REF_BIT] = 1'b1;
        if (is_write) upd_entry[MOD_BIT] = 1'b1;
    end

    assign need_store = (upd_entry != entry);
endmodule

// File: rtl/tblwalk_phys.sv
module tblwalk_phys
    import tblwalk_pkg::*;
(
    input  logic [LVL_W-1:0] lvl,
    input  logic [23:0]      page_num,
    input  logic [23:0]      va_lo,
    output logic [PA_W-1:0]  pa
);
    logic [23:0] offset;

    always_comb begin
        unique case (lvl)
            2'd1:    offset = va_lo;
            2'd2:    offset = {6'b0, va_lo[17:0]};
            2'd3:    offset = {12'b0, va_lo[11:0]};
            default: offset = '0;
        endcase
    end

    assign pa = {page_num, 12'b0} + PA_W'(offset);
endmodule

// File: rtl/tblwalk_top.sv
module tblwalk_top
    import tblwalk_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              walk_start,
    input  logic [VA_W-1:0]   walk_va,
    input  logic              walk_write,
    input  logic              mmu_enable,
    input  logic [31:0]       ctx_table_ptr,
    input  logic [CTX_W-1:0]  ctx_index,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [PA_W-1:0]   mem_addr,
    output logic [ENT_W-1:0]  mem_wdata,
    input  logic              mem_ready,
    input  logic [ENT_W-1:0]  mem_rdata,
    output logic              walk_done,
    output logic [PA_W-1:0]   walk_pa,
    output logic [ENT_W-1:0]  walk_entry,
    output logic [FLT_W-1:0]  walk_fault
);
    walk_state_e      state_q, state_d;
    logic [LVL_W-1:0] lvl_q, lvl_d;
    logic [VA_W-1:0]  va_q, va_d;
    logic             wr_q, wr_d;
    logic [PA_W-1:0]  ptr_q, ptr_d;
    logic [ENT_W-1:0] ent_q, ent_d;
    logic [PA_W-1:0]  pa_q, pa_d;
    logic [FLT_W-1:0] flt_q, flt_d;

    logic [PA_W-1:0]  ctx_addr, next_addr, leaf_pa;
    logic             go_deeper, is_page, need_store;
    logic [FLT_W-1:0] fault_code;
    logic [ENT_W-1:0] upd_entry;
    logic [LVL_W-1:0] lvl_next;

    assign lvl_next = lvl_q + 2'd1;

    tblwalk_index #(.CTX_W(CTX_W)) u_index (
        .next_lvl (lvl_next),
        .va_hi    (va_q[31:12]),
        .desc_hi  (mem_rdata[ENT_W-1:2]),
        .ctx_ptr  (ctx_table_ptr),
        .ctx_num  (ctx_index),
        .ctx_addr (ctx_addr),
        .next_addr(next_addr)
    );

    tblwalk_classify u_classify (
        .lvl       (lvl_q),
        .entry     (mem_rdata),
        .is_write  (wr_q),
        .go_deeper (go_deeper),
        .is_page   (is_page),
        .fault_code(fault_code),
        .upd_entry (upd_entry),
        .need_store(need_store)
    );

    tblwalk_phys u_phys (
        .lvl     (lvl_q),
        .page_num(mem_rdata[31:8]),
        .va_lo   (va_q[23:0]),
        .pa      (leaf_pa)
    );

    // State and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            lvl_q   <= '0;
            va_q    <= '0;
            wr_q    <= 1'b0;
            ptr_q   <= '0;
            ent_q   <= '0;
            pa_q    <= '0;
            flt_q   <= '0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
            va_q    <= va_d;
            wr_q    <= wr_d;
            ptr_q   <= ptr_d;
            ent_q   <= ent_d;
            pa_q    <= pa_d;
            flt_q   <= flt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        va_d    = va_q;
        wr_d    = wr_q;
        ptr_d   = ptr_q;
        ent_d   = ent_q;
        pa_d    = pa_q;
        flt_d   = flt_q;
        unique case (state_q)
            S_IDLE: begin
                if (walk_start) begin
                    va_d  = walk_va;
                    wr_d  = walk_write;
                    ent_d = '0;
                    flt_d = '0;
                    if (!mmu_enable) begin
                        pa_d    = PA_W'(walk_va);
                        state_d = S_REPORT;
                    end else begin
                        pa_d    = '0;
                        lvl_d   = '0;
                        ptr_d   = ctx_addr;
                        state_d = S_FETCH;
                    end
                end
            end
            S_FETCH: begin
                if (mem_ready) begin
                    if (go_deeper) begin
                        lvl_d = lvl_next;
                        ptr_d = next_addr;
                    end else if (is_page) begin
                        ent_d   = upd_entry;
                        pa_d    = leaf_pa;
                        state_d = need_store ? S_STORE : S_REPORT;
                    end else begin
                        ent_d   = mem_rdata;
                        flt_d   = fault_code;
                        pa_d    = '0;
                        state_d = S_REPORT;
                    end
                end
            end
            S_STORE: begin
                if (mem_ready) state_d = S_REPORT;
            end
            S_REPORT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_valid  = (state_q == S_FETCH) || (state_q == S_STORE);
        mem_write  = (state_q == S_STORE);
        mem_addr   = ptr_q;
        mem_wdata  = ent_q;
        walk_done  = (state_q == S_REPORT);
        walk_pa    = pa_q;
        walk_entry = ent_q;
        walk_fault = flt_q;
    end

    // Request stays put while memory stalls (R8)
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                    && $stable(mem_write) && $stable(mem_wdata));

    // Completion is a single-cycle pulse (R9)
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done);

    // No memory traffic while reporting (R9)
    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> !mem_valid);

    // Translation off finishes in one cycle with identity mapping (R1)
    assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) && walk_start && !mmu_enable |=>
            walk_done && !mem_valid && (walk_fault == '0)
            && (walk_pa == PA_W'($past(walk_va))));

    // Fault code layout (R4)
    assert_fault_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> (walk_fault[11:10] == 2'b00) && (walk_fault[7:5] == 3'b000)
                      && (walk_fault[1:0] == 2'b00)
                      && ((walk_fault[4:2] == 3'd0) || (walk_fault[4:2] == FK_INVALID)
                          || (walk_fault[4:2] == FK_XLATE)));

    // Faulting walks give a zero address (R10)
    assert_fault_pa_R10: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done && (walk_fault != '0) |-> (walk_pa == '0));

    // Every stored entry carries the referenced bit (R7)
    assert_store_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_write |-> mem_wdata[REF_BIT]);
endmodule

// File: tb/tblwalk_top_bench.sv
module tblwalk_top_bench;
    localparam int CTX_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        walk_start = 1'b0;
    logic [31:0] walk_va = '0;
    logic        walk_write = 1'b0;
    logic        mmu_enable = 1'b1;
    logic [31:0] ctx_table_ptr = 32'h0000_0100;
    logic [7:0]  ctx_index = 8'd2;
    logic        mem_valid, mem_write, mem_ready;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        walk_done;
    logic [35:0] walk_pa;
    logic [31:0] walk_entry;
    logic [11:0] walk_fault;

    always #4 clk = ~clk;

    tblwalk_top #(.CTX_W(CTX_W)) u_tblwalk_top (
        .clk(clk), .rst_n(rst_n), .walk_start(walk_start), .walk_va(walk_va),
        .walk_write(walk_write), .mmu_enable(mmu_enable),
        .ctx_table_ptr(ctx_table_ptr), .ctx_index(ctx_index),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .walk_done(walk_done), .walk_pa(walk_pa), .walk_entry(walk_entry),
        .walk_fault(walk_fault)
    );

    // Memory model: 64 words, regions 0x1000/0x2000/0x3000/0x4000
    logic [31:0] mem [64];
    logic        stall_mode = 1'b0;
    logic        tog = 1'b0;
    int          rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
    logic [35:0] rd_log [16];
    logic [31:0] last_wdata = '0;

    function automatic int widx(input logic [35:0] a);
        return {a[13:12], a[5:2]};
    endfunction

    assign mem_ready = mem_valid && (!stall_mode || tog);
    assign mem_rdata = mem[widx(mem_addr)];

    always @(posedge clk) begin
        tog <= ~tog;
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= '0;
            mem[widx(36'h1008)] <= 32'h0000_0201;
            mem[widx(36'h1010)] <= 32'h0000_0002;
            mem[widx(36'h1014)] <= 32'h0000_0003;
            mem[widx(36'h2004)] <= 32'h0040_0022;
            mem[widx(36'h2008)] <= 32'h0000_0301;
            mem[widx(36'h2010)] <= 32'h0000_0007;
            mem[widx(36'h2014)] <= 32'h0050_0002;
            mem[widx(36'h3004)] <= 32'h0080_0002;
            mem[widx(36'h3008)] <= 32'h0000_0401;
            mem[widx(36'h3010)] <= 32'h0000_0003;
            mem[widx(36'h400C)] <= 32'h0ABC_DE62;
            mem[widx(36'h4010)] <= 32'h0000_1022;
            mem[widx(36'h4018)] <= 32'h0000_0501;
            mem[widx(36'h401C)] <= 32'h0000_0003;
        end else begin
            if (mem_valid && mem_ready) begin
                if (mem_write) begin
                    mem[widx(mem_addr)] <= mem_wdata;
                    last_wdata <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    rd_log[rd_cnt % 16] <= mem_addr;
                    rd_cnt <= rd_cnt + 1;
                end
            end
            if (walk_done) done_cnt <= done_cnt + 1;
        end
    end

    int checks = 0, failures = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [7:0]  ctx;
        logic [31:0] va;
        logic        wr;
        logic [11:0] flt;
        logic [35:0] pa;
        logic [31:0] pte;
        logic        nwr;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{8'd2, 32'h01AB_CDEF, 1'b0, 12'h000, 36'h0_04AB_CDEF, 32'h0040_0022, 1'b0}, // R6 16MB
        '{8'd2, 32'h0204_5678, 1'b0, 12'h000, 36'h0_0800_5678, 32'h0080_0022, 1'b1}, // R6 256KB, R7 ref
        '{8'd2, 32'h0204_5678, 1'b0, 12'h000, 36'h0_0800_5678, 32'h0080_0022, 1'b0}, // R7 no change
        '{8'd2, 32'h0208_3ABC, 1'b1, 12'h000, 36'h0_ABCD_EABC, 32'h0ABC_DE62, 1'b0}, // R6 4KB
        '{8'd2, 32'h0208_4123, 1'b1, 12'h000, 36'h0_0001_0123, 32'h0000_1062, 1'b1}, // R7 mod
        '{8'd2, 32'h0208_5000, 1'b0, 12'h304, 36'h0,           32'h0000_0000, 1'b0}, // R4 L3 invalid
        '{8'd2, 32'h0208_6000, 1'b0, 12'h310, 36'h0,           32'h0000_0501, 1'b0}, // R5 desc at L3
        '{8'd2, 32'h0208_7000, 1'b0, 12'h310, 36'h0,           32'h0000_0003, 1'b0}, // R4 L3 reserved
        '{8'd2, 32'h020C_0000, 1'b0, 12'h204, 36'h0,           32'h0000_0000, 1'b0}, // R4 L2 invalid
        '{8'd2, 32'h0210_0000, 1'b0, 12'h210, 36'h0,           32'h0000_0003, 1'b0}, // R4 L2 reserved
        '{8'd2, 32'h0300_0000, 1'b0, 12'h104, 36'h0,           32'h0000_0000, 1'b0}, // R4 L1 invalid
        '{8'd2, 32'h0400_0000, 1'b0, 12'h110, 36'h0,           32'h0000_0007, 1'b0}, // R4 L1 reserved
        '{8'd3, 32'h0100_0000, 1'b0, 12'h004, 36'h0,           32'h0000_0000, 1'b0}, // R4 ctx invalid
        '{8'd4, 32'h0100_0000, 1'b0, 12'h010, 36'h0,           32'h0000_0002, 1'b0}, // R5 page in ctx
        '{8'd5, 32'h0100_0000, 1'b0, 12'h010, 36'h0,           32'h0000_0003, 1'b0}, // R4 ctx reserved
        '{8'd2, 32'h0500_0010, 1'b1, 12'h000, 36'h0_0500_0010, 32'h0050_0062, 1'b1}, // R7 ref+mod
        '{8'd2, 32'h0204_5678, 1'b1, 12'h000, 36'h0_0800_5678, 32'h0080_0062, 1'b1}  // R7 mod later
    };

    bit timed_out = 1'b0;

    task automatic wait_done();
        int n = 0;
        while (!walk_done && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (!walk_done) begin
            failures++;
            $display("FAIL R9 no done act=0 exp=1");
        end
    endtask

    task automatic start_walk(input logic [7:0] c, input logic [31:0] va, input logic wr);
        @(negedge clk);
        ctx_index  = c;
        walk_va    = va;
        walk_write = wr;
        walk_start = 1'b1;
        @(negedge clk);
        walk_start = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
        failures++;
        $display("FAIL R9 watchdog act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int rd0, wr0, dn0;
        repeat (4) @(negedge clk);
        // R11 reset state
        check("R11 done", 64'(walk_done), 64'd0);
        check("R11 valid", 64'(mem_valid), 64'd0);
        check("R11 pa", 64'(walk_pa), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            stall_mode = v[0];
            rd0 = rd_cnt;
            wr0 = wr_cnt;
            start_walk(VECS[v].ctx, VECS[v].va, VECS[v].wr);
            wait_done();
            check("R4 fault", 64'(walk_fault), 64'(VECS[v].flt));
            check("R6/R10 pa", 64'(walk_pa), 64'(VECS[v].pa));
            check("R7/R10 entry", 64'(walk_entry), 64'(VECS[v].pte));
            check("R2 first read", 64'(rd_log[rd0 % 16]),
                  64'(36'h1000 + 36'(VECS[v].ctx) * 4));
            if (VECS[v].ctx == 8'd2)
                check("R3 level1 read", 64'(rd_log[(rd0 + 1) % 16]),
                      64'(36'h2000 + 36'(VECS[v].va[31:24]) * 4));
            @(negedge clk);
            check("R7/R10 writes", 64'(wr_cnt - wr0), 64'(VECS[v].nwr));
            if (VECS[v].nwr)
                check("R7 stored entry", 64'(last_wdata), 64'(VECS[v].pte));
        end

        // R3: 4KB walk read path ctx -> L1 -> L2 -> L3
        rd0 = rd_cnt;
        start_walk(8'd2, 32'h0208_3ABC, 1'b0);
        wait_done();
        check("R3 level2 read", 64'(rd_log[(rd0 + 2) % 16]), 64'h3008);
        check("R3 level3 read", 64'(rd_log[(rd0 + 3) % 16]), 64'h400C);

        // R1: translation off
        mmu_enable = 1'b0;
        rd0 = rd_cnt;
        @(negedge clk);
        walk_va = 32'hDEAD_BEEF;
        walk_start = 1'b1;
        @(negedge clk);
        walk_start = 1'b0;
        check("R1 done next cycle", 64'(walk_done), 64'd1);
        check("R1 pa", 64'(walk_pa), 64'h0_DEAD_BEEF);
        check("R1 fault", 64'(walk_fault), 64'd0);
        @(negedge clk);
        check("R1 no reads", 64'(rd_cnt - rd0), 64'd0);
        mmu_enable = 1'b1;

        // R9/R8: start while busy under stalls is ignored
        stall_mode = 1'b1;
        rd0 = rd_cnt;
        dn0 = done_cnt;
        start_walk(8'd2, 32'h01AB_CDEF, 1'b0);
        walk_va = 32'h0300_0000;
        walk_start = 1'b1;
        @(negedge clk);
        walk_start = 1'b0;
        wait_done();
        check("R9 first walk kept", 64'(walk_pa), 64'h0_04AB_CDEF);
        check("R9 no fault", 64'(walk_fault), 64'd0);
        repeat (8) @(negedge clk);
        check("R9 one done", 64'(done_cnt - dn0), 64'd1);
        check("R8 reads", 64'(rd_cnt - rd0), 64'd2);
        check("R9 idle", 64'(mem_valid), 64'd0);

        if (!timed_out) begin
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule